// File: doc/BRIEF.md
# Automatic Sensor Request Scheduler

This block decides when a point-to-point sensor master begins its next sensor-data request cycle. It watches busy and done status from the cycle engine and emits a single-cycle start pulse whenever a new cycle should begin. The start can come from a programmable period timer, from the completion of the previous cycle, or from an external trigger or instruction event. A sticky flag records when the period timer runs out while a cycle is still in progress.

An 8-bit rate code selects how starts are scheduled:

- **Fast periodic:** a fast prescale base of 20 clocks per step.
- **Slow periodic:** a slow base of 625 clocks per step.
- **Back-to-back:** the next cycle starts as soon as the previous one finishes.
- **Trigger-only:** starts come only from trigger events.

Automatic starts require the automatic enable. With the enable cleared, the block still forwards trigger events as starts.

Top module: `sensor_req_sched`

## Requirements
- R1: While reset is asserted, and until the first start source fires, `start_pulse` and `overrun` are 0.
- R2: With `auto_en`=1, codes 0x00 to 0x7B produce start pulses spaced exactly 20*(code+1) clocks apart while `cyc_busy`=0.
- R3: With `auto_en`=1, codes 0x80 to 0xFF produce start pulses spaced exactly 625*(code[6:0]+1) clocks apart while `cyc_busy`=0.
- R4: With `auto_en`=1 and code 0x7C, start pulses follow these rules:
  - A cycle with `cyc_done` high gives a start pulse in the next cycle.
  - Entering this mode with `cyc_busy`=0 gives one start pulse in the cycle after entry.
  - No other pulses are produced.
- R5: With `auto_en`=1 and codes 0x7D to 0x7F, no start pulse occurs without a trigger. An `inst_start` high for one cycle while idle gives a pulse in the next cycle.
- R6: `ext_trig` passes through two synchronizer flops and an edge detector. A rising edge first sampled at clock edge k gives one pulse after edge k+2, and holding the level high gives no further pulses.
- R7: A trigger (`ext_trig` edge or `inst_start`) that arrives while `cyc_busy`=1 produces no start pulse.
- R8: With `auto_en`=0, no timer or back-to-back start occurs, but triggers still produce pulses. With `auto_en`=1 in a periodic or back-to-back code, triggers are ignored.
- R9: If the period expires while `cyc_busy`=1, the following happens:
  - No start pulse is issued.
  - `overrun` is set and stays set until reset.
  - The timer reloads, so the period phase is unchanged.
- R10: A change of `rate_code` in a periodic mode restarts the timer. The first pulse comes P clocks after the edge that samples the new code, where P is the new period.
- R11: `start_pulse` is never high in two consecutive cycles. Sources that fire together yield a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code | input | 8 | Scheduling rate/mode code |
| auto_en | input | 1 | Enables automatic (timer and back-to-back) starts |
| ext_trig | input | 1 | Asynchronous external trigger level |
| inst_start | input | 1 | Synchronous instruction-start request |
| cyc_busy | input | 1 | Cycle engine is running a request cycle |
| cyc_done | input | 1 | One-cycle pulse: cycle engine finished |
| start_pulse | output | 1 | One-cycle request to begin a new cycle |
| overrun | output | 1 | Sticky: period expired while a cycle was busy |

## Verification
Two trigger sources can fire in the same clock: a synchronized external edge and an instruction start. The bench provokes this by raising `inst_start` two clocks after `ext_trig`, so that both requests land on the same edge. It then judges that exactly one pulse appears and that the following cycle is quiet.

A second collision is a period expiry while the engine is busy. The bench holds `cyc_busy` across several expiries and expects the following:
- No pulse during the busy stretch.
- A set overrun flag.
- Resumption on the original phase afterwards.

// File: rtl/sreq_pkg.sv
package sreq_pkg;

  typedef enum logic [1:0] {
    SM_FAST   = 2'd0,
    SM_SLOW   = 2'd1,
    SM_B2B    = 2'd2,
    SM_TRIG   = 2'd3
  } sreq_mode_e;

  // Classify a rate code: top half is slow-base periodic; bottom half is
  // fast periodic below the back-to-back code, trigger-only above it.
  function automatic sreq_mode_e code_mode(input logic [7:0] code,
                                           input logic [7:0] b2b_code);
    if (code[7])
      return SM_SLOW;
    else if (code == b2b_code)
      return SM_B2B;
    else if (code > b2b_code)
      return SM_TRIG;
    else
      return SM_FAST;
  endfunction

  // Period in clocks: base times (low seven bits + 1).
  function automatic int unsigned code_period(input logic [7:0] code,
                                              input int unsigned fast_base,
                                              input int unsigned slow_base);
    int unsigned steps;
    steps = int'(code[6:0]) + 1;
    return (code[7] ? slow_base : fast_base) * steps;
  endfunction

endpackage

// File: rtl/sreq_rate_decode.sv
module sreq_rate_decode
  import sreq_pkg::*;
#(
  parameter int          CODE_W    = 8,
  parameter int unsigned FAST_BASE = 20,
  parameter int unsigned SLOW_BASE = 625,
  parameter logic [7:0]  B2B_CODE  = 8'h7C,
  parameter int          CNT_W     = 17
) (
  input  logic [CODE_W-1:0] code,
  output sreq_mode_e        mode,
  output logic [CNT_W-1:0]  period
);

  logic [7:0]  code8;
  int unsigned period_full;

  generate
    if (CODE_W >= 8) begin : g_trunc
      assign code8 = code[7:0];
    end else begin : g_pad
      assign code8 = {code[CODE_W-1], {(8-CODE_W){1'b0}}, code[CODE_W-2:0]};
    end
  endgenerate

  always_comb begin
    mode        = code_mode(code8, B2B_CODE);
    period_full = code_period(code8, FAST_BASE, SLOW_BASE);
    period      = period_full[CNT_W-1:0];
  end

endmodule

// File: rtl/sreq_trig_sync.sv
module sreq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/sreq_period_timer.sv
module sreq_period_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = period - CNT_W'(1);
  assign expire   = run && !restart && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || restart || expire)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/sensor_req_sched.sv
module sensor_req_sched
  import sreq_pkg::*;
#(
  parameter int          CODE_W      = 8,
  parameter int unsigned FAST_BASE   = 20,
  parameter int unsigned SLOW_BASE   = 625,
  parameter logic [7:0]  B2B_CODE    = 8'h7C,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              auto_en,
  input  logic              ext_trig,
  input  logic              inst_start,
  input  logic              cyc_busy,
  input  logic              cyc_done,
  output logic              start_pulse,
  output logic              overrun
);

  localparam int unsigned MAX_PERIOD = SLOW_BASE * (2 ** (CODE_W - 1));
  localparam int          CNT_W      = $clog2(MAX_PERIOD + 1);

  sreq_mode_e       mode;
  logic [CNT_W-1:0] period;
  logic [CODE_W-1:0] code_q;
  logic             code_chg;
  logic             periodic_on;
  logic             b2b_on, b2b_on_q, b2b_kick, b2b_req;
  logic             trig_open, trig_any, trig_req;
  logic             ext_rise;
  logic             tmr_expire, per_req, ovr_set;
  logic             start_req, start_q, overrun_q;

  sreq_rate_decode #(
    .CODE_W(CODE_W), .FAST_BASE(FAST_BASE), .SLOW_BASE(SLOW_BASE),
    .B2B_CODE(B2B_CODE), .CNT_W(CNT_W)
  ) u_decode (
    .code(rate_code), .mode(mode), .period(period)
  );

  sreq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_trig), .rise(ext_rise)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= rate_code;
  end
  assign code_chg = (rate_code != code_q);

  assign periodic_on = auto_en && (mode == SM_FAST || mode == SM_SLOW);

  sreq_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(periodic_on), .restart(code_chg),
    .period(period), .expire(tmr_expire)
  );

  assign per_req = tmr_expire && !cyc_busy;
  assign ovr_set = tmr_expire && cyc_busy;

  // Back-to-back: restart on completion, plus one kick on entry when idle.
  assign b2b_on = auto_en && (mode == SM_B2B);
  always_ff @(posedge clk) begin
    if (!rst_n) b2b_on_q <= 1'b0;
    else        b2b_on_q <= b2b_on;
  end
  assign b2b_kick = b2b_on && !b2b_on_q && !cyc_busy;
  assign b2b_req  = b2b_on && (cyc_done || b2b_kick);

  // Triggers count when automatic mode is off or trigger-only is selected.
  assign trig_open = !auto_en || (mode == SM_TRIG);
  assign trig_any  = ext_rise || inst_start;
  assign trig_req  = trig_open && trig_any && !cyc_busy;

  assign start_req = (per_req || b2b_req || trig_req) && !start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      start_q   <= start_req;
      overrun_q <= overrun_q || ovr_set;
    end
  end

  assign start_pulse = start_q;
  assign overrun     = overrun_q;

endmodule

// File: rtl/sreq_checks.sv
module sreq_checks (
  input logic clk,
  input logic rst_n,
  input logic start_pulse,
  input logic overrun,
  input logic cyc_busy,
  input logic cyc_done,
  input logic auto_en,
  input logic tmr_expire,
  input logic trig_any,
  input logic b2b_on
);

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(tmr_expire && cyc_busy));

  assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !$past(b2b_on)) |-> !$past(cyc_busy));

  assert_manual_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !$past(auto_en)) |-> $past(trig_any));

  assert_b2b_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && $past(b2b_on)) |-> ($past(cyc_done) || !$past(cyc_busy)));

endmodule

bind sensor_req_sched sreq_checks u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .overrun(overrun),
  .cyc_busy(cyc_busy), .cyc_done(cyc_done), .auto_en(auto_en),
  .tmr_expire(tmr_expire), .trig_any(trig_any), .b2b_on(b2b_on)
);

// File: tb/sensor_req_sched_bench.sv
`timescale 1ns/1ps
module sensor_req_sched_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_code = 8'h00;
  logic       auto_en = 1'b0;
  logic       ext_trig = 1'b0;
  logic       inst_start = 1'b0;
  logic       cyc_busy = 1'b0;
  logic       cyc_done = 1'b0;
  logic       start_pulse, overrun;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sensor_req_sched u_sensor_req_sched (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .auto_en(auto_en),
    .ext_trig(ext_trig), .inst_start(inst_start), .cyc_busy(cyc_busy),
    .cyc_done(cyc_done), .start_pulse(start_pulse), .overrun(overrun)
  );

  // Expected period: slow codes step by 625, fast codes step by 20.
  function automatic int exp_period(input logic [7:0] c);
    if (c >= 8'h80) return 625 * (int'(c) - 127);
    return 20 * (int'(c) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Negedges until start_pulse seen (1-based), -1 if not within limit.
  task automatic wait_pulse(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      tick();
      if (start_pulse) begin n = i; break; end
    end
  endtask

  task automatic count_pulses(input int span, output int c);
    c = 0;
    for (int i = 0; i < span; i++) begin
      tick();
      if (start_pulse) c++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    auto_en = 1'b0; ext_trig = 1'b0; inst_start = 1'b0;
    cyc_busy = 1'b0; cyc_done = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, c, p;
    logic [7:0] code, prev;
    void'($urandom(32'd4711));

    // R1 reset state
    repeat (2) tick();
    check(start_pulse == 0 && overrun == 0, "R1 in reset", {start_pulse, overrun}, 0);
    do_reset();
    count_pulses(10, c);
    check(c == 0 && overrun == 0, "R1 after reset", c, 0);

    // R2 + R10: fast periodic codes, changing code while running
    rate_code = 8'h05; tick(); auto_en = 1'b1;
    wait_pulse(300, n);
    prev = 8'h05;
    for (int it = 0; it < 4; it++) begin
      code = 8'($urandom_range(0, 8'h7B));
      if (code == prev) code = (code == 8'h00) ? 8'h01 : code - 8'h01;
      rate_code = code; prev = code;
      p = exp_period(code);
      wait_pulse(p + 10, n);
      check(n == p + 1, "R10 first pulse after code change", n, p + 1);
      wait_pulse(p + 10, n);
      check(n == p, "R2 fast period", n, p);
      tick();
      check(start_pulse == 0, "R11 one-cycle width", start_pulse, 0);
    end

    // R3: slow periodic codes
    for (int it = 0; it < 2; it++) begin
      code = 8'h80 + 8'(it + $urandom_range(0, 1) * 2);
      rate_code = code;
      p = exp_period(code);
      wait_pulse(p + 10, n);
      check(n == p + 1, "R10 slow first pulse", n, p + 1);
      wait_pulse(p + 10, n);
      check(n == p, "R3 slow period", n, p);
    end

    // R8: triggers ignored in periodic mode with auto on
    rate_code = 8'h80;
    wait_pulse(700, n);
    inst_start = 1'b1; tick(); inst_start = 1'b0;
    check(start_pulse == 0, "R8 inst ignored in periodic", start_pulse, 0);
    count_pulses(100, c);
    check(c == 0, "R8 no trigger pulse in periodic", c, 0);

    // R8: auto off -> no automatic starts, triggers accepted
    auto_en = 1'b0; rate_code = 8'h00;
    count_pulses(100, c);
    check(c == 0, "R8 no auto start when disabled", c, 0);
    inst_start = 1'b1; tick(); inst_start = 1'b0;
    check(start_pulse == 1, "R8 trigger when disabled", start_pulse, 1);

    // R4: back-to-back mode
    rate_code = 8'h7C; repeat (3) tick();
    auto_en = 1'b1;
    wait_pulse(5, n);
    check(n == 1, "R4 entry kick", n, 1);
    cyc_busy = 1'b1;
    count_pulses(5, c);
    check(c == 0, "R4 quiet while busy", c, 0);
    for (int it = 0; it < 3; it++) begin
      repeat ($urandom_range(2, 10)) tick();
      cyc_done = 1'b1; cyc_busy = 1'b0; tick();
      check(start_pulse == 1, "R4 restart after done", start_pulse, 1);
      cyc_done = 1'b0; cyc_busy = 1'b1;
    end
    cyc_busy = 1'b0;
    count_pulses(20, c);
    check(c == 0, "R4 no start without done", c, 0);
    auto_en = 1'b0; repeat (3) tick();

    // R5: trigger-only mode
    rate_code = 8'($urandom_range(8'h7D, 8'h7F)); auto_en = 1'b1;
    count_pulses(200, c);
    check(c == 0, "R5 no auto start", c, 0);
    inst_start = 1'b1; tick(); inst_start = 1'b0;
    check(start_pulse == 1, "R5 inst start", start_pulse, 1);
    tick();
    check(start_pulse == 0, "R11 width in trigger mode", start_pulse, 0);

    // R6: external trigger latency and one pulse per edge
    ext_trig = 1'b1;
    wait_pulse(10, n);
    check(n == 3, "R6 ext latency", n, 3);
    count_pulses(20, c);
    check(c == 0, "R6 level held gives no repeat", c, 0);
    ext_trig = 1'b0; repeat (5) tick();
    ext_trig = 1'b1;
    wait_pulse(10, n);
    check(n == 3, "R6 second edge", n, 3);

    // R7: triggers while busy ignored
    ext_trig = 1'b0; repeat (5) tick();
    cyc_busy = 1'b1; ext_trig = 1'b1; inst_start = 1'b1;
    tick(); inst_start = 1'b0;
    count_pulses(10, c);
    check(c == 0, "R7 busy ignores triggers", c, 0);
    cyc_busy = 1'b0; ext_trig = 1'b0; repeat (5) tick();

    // R11: coincident external edge and instruction start
    auto_en = 1'b0;
    ext_trig = 1'b1; tick(); tick();
    inst_start = 1'b1; tick();
    check(start_pulse == 1, "R11 coincident sources pulse", start_pulse, 1);
    inst_start = 1'b0; tick();
    check(start_pulse == 0, "R11 single pulse", start_pulse, 0);
    count_pulses(10, c);
    check(c == 0, "R11 no extra pulse", c, 0);
    ext_trig = 1'b0; repeat (5) tick();

    // R9: expiry while busy
    check(overrun == 0, "R9 overrun clear before", overrun, 0);
    rate_code = 8'h00; auto_en = 1'b1;
    wait_pulse(50, n);
    cyc_busy = 1'b1;
    count_pulses(60, c);
    check(c == 0, "R9 no start while busy", c, 0);
    check(overrun == 1, "R9 overrun set", overrun, 1);
    cyc_busy = 1'b0;
    wait_pulse(50, n);
    check(n == 20, "R9 phase kept after reload", n, 20);
    check(overrun == 1, "R9 overrun sticky", overrun, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule